// File: doc/BRIEF.md
# Duplex Ripple-Carry Adder with Stuck-At Injection

The block holds two ripple-carry adders of equal width that receive the same operands and carry-in, and a comparator that flags an error when their results disagree. A third, fault-free adder serves as the golden reference. With it, every applied pattern can be placed in one of four outcome classes. The dangerous class is the one where both copies are wrong in the same way. No mismatch is raised there, so the corruption is silent.

Each copy has its own injection port. The port forces one net of one full-adder stage to a constant 0 or 1. A diversity mode feeds the second copy bitwise-inverted operands. An adder is self-dual, so that copy then produces the inverted result. The result is re-inverted before the comparison. Its internal nets therefore carry different values from those of the first copy, and an identical defect no longer has to produce an identical error. The block is intended for studying how fault pairs escape detection. Outputs can be registered once.

Top module: `dup_adder_top`

## Requirements
- R1: With neither injection port enabled, `res_o` equals a+b+cin as a WIDTH+1 bit value with the carry-out in the top bit, `err_o` is 0 and `cls_o` is 0.
- R2: An injection port takes effect only when its enable is 1 and its stage index is below WIDTH (0 is the least significant stage) and its net code is one of: 0 operand a, 1 operand b, 2 carry-in, 3 a XOR b, 4 a AND b, 5 (a XOR b) AND carry-in, 6 the OR output, 7 sum, 8 carry-out. The net is then held at the stuck value. Otherwise the port has no effect.
- R3: `err_o` is 1 exactly when the first copy's result and the second copy's decoded result differ in any bit.
- R4: With `inv_mode`=1 the second copy receives inverted operands and carry-in, and its output is inverted before comparison. Without faults `err_o` stays 0. The same stuck net in both copies can then give a detected error where the plain mode gives silent corruption.
- R5: `cls_o` encodes the outcome against the fault-free reference: 0 both copies correct, 1 exactly one copy wrong, 2 both wrong with equal values, 3 both wrong with different values.
- R6: `silent_o` is 1 exactly when `cls_o` is 2, and it is never 1 together with `err_o`.
- R7: A stuck carry-out on stage i that flips that carry appears in `res_o` at bit i+1; for the top stage that is the carry-out bit.
- R8: When both ports are enabled on stages whose indices differ by more than one, `silent_o` never asserts, and every wrong `res_o` comes with `err_o`=1.
- R9: A fault in only one copy never yields `silent_o`=1.
- R10: With REG_OUT=1 all outputs change one rising edge after their inputs, and synchronous reset clears them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | WIDTH | Operand A |
| b | input | WIDTH | Operand B |
| cin | input | 1 | Carry-in |
| inv_mode | input | 1 | Second copy works on inverted data |
| flt0_en | input | 1 | Enable injection in copy 0 |
| flt0_stage | input | SW | Stage index for copy 0 |
| flt0_net | input | 4 | Net code for copy 0 |
| flt0_val | input | 1 | Stuck value for copy 0 |
| flt1_en | input | 1 | Enable injection in copy 1 |
| flt1_stage | input | SW | Stage index for copy 1 |
| flt1_net | input | 4 | Net code for copy 1 |
| flt1_val | input | 1 | Stuck value for copy 1 |
| res_o | output | WIDTH+1 | Result of copy 0 |
| err_o | output | 1 | Copies disagree |
| silent_o | output | 1 | Identical wrong results |
| cls_o | output | 2 | Outcome class |

## Verification
Every result is due one rising edge after the operands and fault controls are applied, because the adders and the classifier are purely combinational ahead of a single output register. The bench changes inputs on the falling edge and samples 1 ns after the next rising edge. The latency check also samples just before that edge to confirm the old value still holds. During the exhaustive sweep over non-adjacent fault pairs, a new pattern is applied every cycle. Its check falls in the same one-edge window, so each pattern is judged against its own registered outcome.

// File: rtl/dup_pkg.sv
package dup_pkg;

    localparam int NUM_NETS = 9;

    typedef enum logic [3:0] {
        NET_A  = 4'd0,
        NET_B  = 4'd1,
        NET_CI = 4'd2,
        NET_X  = 4'd3,
        NET_G  = 4'd4,
        NET_T  = 4'd5,
        NET_OR = 4'd6,
        NET_S  = 4'd7,
        NET_CO = 4'd8
    } fa_net_e;

    typedef enum logic [1:0] {
        CLS_CLEAN  = 2'd0,
        CLS_ONE    = 2'd1,
        CLS_SILENT = 2'd2,
        CLS_SPLIT  = 2'd3
    } cls_e;

    typedef struct packed {
        logic       en;
        logic [3:0] net;
        logic       val;
    } stage_flt_t;

    function automatic logic force_net(logic v, logic hit, logic sv);
        return hit ? sv : v;
    endfunction

endpackage

// File: rtl/dup_fa_stage.sv
module dup_fa_stage
    import dup_pkg::*;
(
    input  logic       a,
    input  logic       b,
    input  logic       ci,
    input  stage_flt_t flt,
    output logic       s,
    output logic       co
);
    logic [NUM_NETS-1:0] hit;
    logic ax, bx, cx, x, g, t, o;

    always_comb begin
        for (int k = 0; k < NUM_NETS; k++) begin
            hit[k] = flt.en && (flt.net == 4'(k));
        end
    end

    assign ax = force_net(a, hit[NET_A], flt.val);
    assign bx = force_net(b, hit[NET_B], flt.val);
    assign cx = force_net(ci, hit[NET_CI], flt.val);
    assign x  = force_net(ax ^ bx, hit[NET_X], flt.val);
    assign g  = force_net(ax & bx, hit[NET_G], flt.val);
    assign t  = force_net(x & cx, hit[NET_T], flt.val);
    assign o  = force_net(g | t, hit[NET_OR], flt.val);
    assign s  = force_net(x ^ cx, hit[NET_S], flt.val);
    assign co = force_net(o, hit[NET_CO], flt.val);

endmodule

// File: rtl/dup_rc_chain.sv
module dup_rc_chain
    import dup_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int SW    = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             ci,
    input  logic             flt_en,
    input  logic [SW-1:0]    flt_stage,
    input  logic [3:0]       flt_net,
    input  logic             flt_val,
    output logic [WIDTH:0]   res
);
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sum;

    assign carry[0] = ci;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        stage_flt_t sf;
        assign sf.en  = flt_en && (int'(flt_stage) == i);
        assign sf.net = flt_net;
        assign sf.val = flt_val;

        dup_fa_stage u_fa (
            .a  (a[i]),
            .b  (b[i]),
            .ci (carry[i]),
            .flt(sf),
            .s  (sum[i]),
            .co (carry[i+1])
        );
    end

    assign res = {carry[WIDTH], sum};

endmodule

// File: rtl/dup_judge.sv
module dup_judge
    import dup_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH:0] gold,
    input  logic [WIDTH:0] r0,
    input  logic [WIDTH:0] r1_raw,
    input  logic           inv,
    output logic           err,
    output cls_e           cls,
    output logic           silent
);
    logic [WIDTH:0] r1;
    logic           w0, w1;

    assign r1  = inv ? ~r1_raw : r1_raw;
    assign w0  = (r0 != gold);
    assign w1  = (r1 != gold);
    assign err = (r0 != r1);

    always_comb begin
        unique case ({w0, w1})
            2'b00:        cls = CLS_CLEAN;
            2'b01, 2'b10: cls = CLS_ONE;
            default:      cls = err ? CLS_SPLIT : CLS_SILENT;
        endcase
    end

    assign silent = (cls == CLS_SILENT);

endmodule

// File: rtl/dup_adder_top.sv
module dup_adder_top
    import dup_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter bit REG_OUT = 1'b1,
    parameter int SW      = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic             inv_mode,
    input  logic             flt0_en,
    input  logic [SW-1:0]    flt0_stage,
    input  logic [3:0]       flt0_net,
    input  logic             flt0_val,
    input  logic             flt1_en,
    input  logic [SW-1:0]    flt1_stage,
    input  logic [3:0]       flt1_net,
    input  logic             flt1_val,
    output logic [WIDTH:0]   res_o,
    output logic             err_o,
    output logic             silent_o,
    output logic [1:0]       cls_o
);
    logic [WIDTH-1:0] a1, b1;
    logic             c1;
    logic [WIDTH:0]   gold, r0, r1_raw;
    logic             err_c, silent_c;
    cls_e             cls_c;
    logic             far_pair;

    assign a1 = inv_mode ? ~a : a;
    assign b1 = inv_mode ? ~b : b;
    assign c1 = inv_mode ? ~cin : cin;

    dup_rc_chain #(.WIDTH(WIDTH), .SW(SW)) u_gold (
        .a(a), .b(b), .ci(cin),
        .flt_en(1'b0), .flt_stage('0), .flt_net(4'd0), .flt_val(1'b0),
        .res(gold)
    );

    dup_rc_chain #(.WIDTH(WIDTH), .SW(SW)) u_copy0 (
        .a(a), .b(b), .ci(cin),
        .flt_en(flt0_en), .flt_stage(flt0_stage), .flt_net(flt0_net), .flt_val(flt0_val),
        .res(r0)
    );

    dup_rc_chain #(.WIDTH(WIDTH), .SW(SW)) u_copy1 (
        .a(a1), .b(b1), .ci(c1),
        .flt_en(flt1_en), .flt_stage(flt1_stage), .flt_net(flt1_net), .flt_val(flt1_val),
        .res(r1_raw)
    );

    dup_judge #(.WIDTH(WIDTH)) u_judge (
        .gold(gold), .r0(r0), .r1_raw(r1_raw), .inv(inv_mode),
        .err(err_c), .cls(cls_c), .silent(silent_c)
    );

    assign far_pair = flt0_en && flt1_en &&
                      ((int'(flt0_stage) > int'(flt1_stage) + 1) ||
                       (int'(flt1_stage) > int'(flt0_stage) + 1));

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                res_o    <= '0;
                err_o    <= 1'b0;
                silent_o <= 1'b0;
                cls_o    <= 2'd0;
            end else begin
                res_o    <= r0;
                err_o    <= err_c;
                silent_o <= silent_c;
                cls_o    <= cls_c;
            end
        end

        AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (rst)
            (!flt0_en && !flt1_en) |=> (cls_o == 2'd0 && !err_o)); // R1
        AST_SILENT_QUIET: assert property (@(posedge clk) disable iff (rst)
            silent_o |-> (!err_o && cls_o == 2'd2)); // R6
        AST_FAR_PAIR_SAFE: assert property (@(posedge clk) disable iff (rst)
            far_pair |=> !silent_o); // R8
        AST_LONE_FAULT_SAFE: assert property (@(posedge clk) disable iff (rst)
            (flt0_en != flt1_en) |=> !silent_o); // R9
        AST_ERR_CLASS: assert property (@(posedge clk) disable iff (rst)
            err_o |-> (cls_o == 2'd1 || cls_o == 2'd3)); // R5
    end else begin : g_comb
        assign res_o    = r0;
        assign err_o    = err_c;
        assign silent_o = silent_c;
        assign cls_o    = cls_c;
    end

endmodule

// File: tb/sim_dup_adder_top.sv
`timescale 1ns/1ps
module sim_dup_adder_top;
    localparam int W  = 3;
    localparam int SW = $clog2(W);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  a = '0, b = '0;
    logic          cin = 1'b0, inv_mode = 1'b0;
    logic          f0_en = 1'b0, f0_val = 1'b0, f1_en = 1'b0, f1_val = 1'b0;
    logic [SW-1:0] f0_st = '0, f1_st = '0;
    logic [3:0]    f0_net = '0, f1_net = '0;
    logic [W:0]    res;
    logic          err, silent;
    logic [1:0]    cls;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    dup_adder_top #(.WIDTH(W), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .inv_mode(inv_mode),
        .flt0_en(f0_en), .flt0_stage(f0_st), .flt0_net(f0_net), .flt0_val(f0_val),
        .flt1_en(f1_en), .flt1_stage(f1_st), .flt1_net(f1_net), .flt1_val(f1_val),
        .res_o(res), .err_o(err), .silent_o(silent), .cls_o(cls)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_f0(logic en, int st, int net, logic v);
        f0_en = en; f0_st = SW'(st); f0_net = 4'(net); f0_val = v;
    endtask

    task automatic set_f1(logic en, int st, int net, logic v);
        f1_en = en; f1_st = SW'(st); f1_net = 4'(net); f1_val = v;
    endtask

    task automatic apply(int av, int bv, logic cv);
        @(negedge clk);
        a = W'(av); b = W'(bv); cin = cv;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_all(string req, int r, logic e, int c, logic s);
        chk(req, "res", int'(res), r);
        chk(req, "err", int'(err), int'(e));
        chk(req, "cls", int'(cls), c);
        chk(req, "silent", int'(silent), int'(s));
    endtask

    task automatic t_reset();
        a = 3'd5; b = 3'd6; cin = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        expect_all("R10", 0, 1'b0, 0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_clean();
        set_f0(1'b0, 0, 0, 1'b0); set_f1(1'b0, 0, 0, 1'b0);
        inv_mode = 1'b0;
        apply(3, 4, 1'b1); expect_all("R1", 8, 1'b0, 0, 1'b0);
        apply(7, 7, 1'b1); expect_all("R1", 15, 1'b0, 0, 1'b0);
        apply(5, 2, 1'b0); expect_all("R1", 7, 1'b0, 0, 1'b0);
        inv_mode = 1'b1;
        apply(6, 3, 1'b1); expect_all("R4", 10, 1'b0, 0, 1'b0);
        apply(0, 0, 1'b0); expect_all("R4", 0, 1'b0, 0, 1'b0);
        inv_mode = 1'b0;
    endtask

    task automatic t_latency();
        apply(1, 1, 1'b0);
        @(negedge clk);
        a = 3'd7; b = 3'd0; cin = 1'b0;
        #1;
        chk("R10", "res before edge", int'(res), 2);
        @(posedge clk);
        #1;
        chk("R10", "res after edge", int'(res), 7);
    endtask

    task automatic t_port_gating();
        set_f0(1'b0, 0, 7, 1'b1);
        apply(0, 0, 1'b0); expect_all("R2 disabled", 0, 1'b0, 0, 1'b0);
        set_f0(1'b1, 0, 9, 1'b1);
        apply(0, 0, 1'b0); expect_all("R2 net code 9", 0, 1'b0, 0, 1'b0);
        set_f0(1'b1, 3, 7, 1'b1);
        apply(0, 0, 1'b0); expect_all("R2 stage 3", 0, 1'b0, 0, 1'b0);
        set_f0(1'b1, 0, 7, 1'b0);
        apply(0, 0, 1'b0); expect_all("R2 unexcited", 0, 1'b0, 0, 1'b0);
        set_f0(1'b1, 1, 1, 1'b1);
        apply(0, 0, 1'b0); expect_all("R2 b stage1", 2, 1'b1, 1, 1'b0);
        set_f0(1'b0, 0, 0, 1'b0);
    endtask

    task automatic t_one_copy();
        set_f1(1'b1, 0, 0, 1'b1);
        apply(0, 0, 1'b0); expect_all("R3 R9", 0, 1'b1, 1, 1'b0);
        set_f1(1'b0, 0, 0, 1'b0);
    endtask

    task automatic t_carry();
        for (int i = 0; i < W; i++) begin
            set_f0(1'b1, i, 8, 1'b1);
            apply(0, 0, 1'b0);
            expect_all("R7", 1 << (i + 1), 1'b1, 1, 1'b0);
        end
        set_f0(1'b0, 0, 0, 1'b0);
    endtask

    task automatic t_pairs();
        set_f0(1'b1, 1, 7, 1'b0); set_f1(1'b1, 1, 7, 1'b0);
        inv_mode = 1'b0;
        apply(2, 0, 1'b0); expect_all("R5 R6 same site", 0, 1'b0, 2, 1'b1);
        inv_mode = 1'b1;
        apply(2, 0, 1'b0); expect_all("R4 diverse", 0, 1'b1, 1, 1'b0);
        inv_mode = 1'b0;
        set_f0(1'b1, 0, 7, 1'b1); set_f1(1'b1, 1, 7, 1'b1);
        apply(0, 0, 1'b0); expect_all("R5 split", 1, 1'b1, 3, 1'b0);
        set_f0(1'b0, 0, 0, 1'b0); set_f1(1'b0, 0, 0, 1'b0);
    endtask

    task automatic t_sweep_far();
        inv_mode = 1'b0;
        for (int s0 = 0; s0 < W; s0++) begin
            for (int s1 = 0; s1 < W; s1++) begin
                if (s0 - s1 > 1 || s1 - s0 > 1) begin
                    for (int n0 = 0; n0 < 9; n0++) begin
                        for (int v0 = 0; v0 < 2; v0++) begin
                            for (int n1 = 0; n1 < 9; n1++) begin
                                for (int v1 = 0; v1 < 2; v1++) begin
                                    int bad = 0;
                                    int act_s = 0, act_r = 0, exp_r = 0;
                                    set_f0(1'b1, s0, n0, v0[0]);
                                    set_f1(1'b1, s1, n1, v1[0]);
                                    for (int p = 0; p < 128; p++) begin
                                        int e;
                                        apply(p & 7, (p >> 3) & 7, p[6]);
                                        e = (p & 7) + ((p >> 3) & 7) + ((p >> 6) & 1);
                                        if (bad == 0 && (silent || (int'(res) != e && !err))) begin
                                            bad = 1;
                                            act_s = int'(silent); act_r = int'(res); exp_r = e;
                                        end
                                    end
                                    checks++;
                                    if (bad != 0) begin
                                        errors++;
                                        $display("FAIL R8 pair s%0d/n%0d/v%0d s%0d/n%0d/v%0d: actual silent %0d res %0d expected silent 0 res %0d",
                                                 s0, n0, v0, s1, n1, v1, act_s, act_r, exp_r);
                                    end
                                end
                            end
                        end
                    end
                end
            end
        end
        set_f0(1'b0, 0, 0, 1'b0); set_f1(1'b0, 0, 0, 1'b0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        t_reset();
        t_clean();
        t_latency();
        t_port_gating();
        t_one_copy();
        t_carry();
        t_pairs();
        t_sweep_far();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule